// File: doc/BRIEF.md
# Audio Clock Source Switch Controller

This block sequences the choice of sample clock for an audio path. There are two sources: a clock divided down from a local crystal and a clock recovered from the digital audio input. A one-cycle start strobe begins a sequence. The controller works out the target source from a mode setting and the type of input in use. If the source must change, it mutes the DAC around the change. After a move onto the recovered clock it waits a fixed settling time. It then issues the downstream strobes: a divider load, an input resync and a clock-modify request.

The controller keeps a current-frequency register. It updates that register only when a request asks for a different rate. While the recovered clock is selected, it also tracks the rate reported by an external detector, and it accepts only the three standard rates. A stale flag blocks every new request. The settling wait is measured in system clock cycles and derived from the clock rate in kHz and the delay in ms. Computing the divider word itself is left to other logic.

Top module: `clk_src_switch`

## Requirements
- R1: Mode encoding on mode_i: 0 internal, 1 external, 2 auto, 3 treated as internal. External, or auto with dig_in_i high, selects the recovered clock (src_sel_o=1). Internal, or auto with dig_in_i low, selects the crystal clock (src_sel_o=0).
- R2: When the target differs from the current source, dac_mute_o rises at least one cycle before src_sel_o changes, is still high in the cycle the new select appears, and falls afterwards. When the source does not change, dac_mute_o stays low.
- R3: After a switch to the recovered clock, the next output event (clk_mod_o, or busy_o falling) comes exactly SETTLE_CYC+1 cycles after dac_mute_o falls, where SETTLE_CYC = CLK_KHZ*SETTLE_MS. A switch to the crystal clock has no wait, so the next event follows one cycle after the fall.
- R4: When the request equals the current frequency, the sequence ends without div_load_o, resync_in_o or clk_mod_o, and cur_freq_o is unchanged.
- R5: On the crystal path with a new frequency, div_load_o pulses for one cycle with div_freq_o equal to the request. resync_in_o pulses in the following cycle only if the source changed in this sequence.
- R6: When the request differs from cur_freq_o, clk_mod_o pulses once with clk_mod_sync_o high, and cur_freq_o takes the request as busy_o falls. On the recovered path no div_load_o is issued.
- R7: While stale_i is high, start_i is ignored: busy_o, src_sel_o, dac_mute_o and all strobes keep their values.
- R8: While the recovered clock is selected and stale_i is low, a det_valid_i with det_freq_i of exactly 32000, 44100 or 48000 loads trk_freq_o. Any other value, and any report while the crystal clock is selected, leaves trk_freq_o unchanged.
- R9: busy_o is high from the cycle after an accepted start until the sequence ends. While busy_o is low, no mute or strobe is active.
- R10: After reset: src_sel_o=0, dac_mute_o=0, busy_o=0, cur_freq_o=0, trk_freq_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Clock mode (0 internal, 1 external, 2 auto, 3 internal) |
| dig_in_i | input | 1 | Digital audio input in use |
| freq_req_i | input | FREQ_W | Requested sample rate in Hz |
| stale_i | input | 1 | Blocks requests and rate tracking |
| start_i | input | 1 | Begin a sequence |
| det_valid_i | input | 1 | Detector rate report valid |
| det_freq_i | input | FREQ_W | Detected rate in Hz |
| src_sel_o | output | 1 | 0 crystal clock, 1 recovered clock |
| dac_mute_o | output | 1 | DAC mute during a switch |
| div_load_o | output | 1 | Divider load strobe |
| div_freq_o | output | FREQ_W | Rate for the divider to load |
| resync_in_o | output | 1 | Input resync pulse |
| clk_mod_o | output | 1 | Clock-modify pulse |
| clk_mod_sync_o | output | 1 | FIFO resync flag of the clock-modify pulse |
| busy_o | output | 1 | Sequence in progress |
| cur_freq_o | output | FREQ_W | Current frequency |
| trk_freq_o | output | FREQ_W | Tracked detected frequency |

## Verification
Sequences are requested for every mode, with the digital-input flag both set and clear. Each is tried with the source unchanged and with it changing, and with a new or a repeated frequency. This separates the four kinds of path: the quiet no-op, the load without resync, the load with resync, and the settling wait that only the recovered clock gets. A request under the stale flag and one with mode 3 test the blocking rule and the mode encoding. Rate reports with legal and illegal values, given while each source is selected, separate the acceptance filter from the dependence on the selected source.

// File: rtl/ckss_pkg.sv
package ckss_pkg;
  typedef enum logic [1:0] {
    MODE_INT  = 2'd0,
    MODE_EXT  = 2'd1,
    MODE_AUTO = 2'd2,
    MODE_RSV  = 2'd3
  } clk_mode_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_SWAP, ST_UNMUTE, ST_SETTLE,
    ST_FREQ, ST_LOAD, ST_RESYNC, ST_MODIFY
  } seq_st_e;

  localparam logic SRC_XTAL = 1'b0;
  localparam logic SRC_REC  = 1'b1;
endpackage

// File: rtl/ckss_target.sv
module ckss_target
  import ckss_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       dig_in_i,
  output logic       want_rec_o
);
  clk_mode_e mode;
  assign mode = clk_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_EXT:  want_rec_o = SRC_REC;
      MODE_AUTO: want_rec_o = dig_in_i ? SRC_REC : SRC_XTAL;
      default:   want_rec_o = SRC_XTAL;
    endcase
  end
endmodule

// File: rtl/ckss_settle.sv
module ckss_settle #(
  parameter int unsigned LIMIT = 600000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ckss_rate_track.sv
module ckss_rate_track #(
  parameter int unsigned FREQ_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              det_valid_i,
  input  logic [FREQ_W-1:0] det_freq_i,
  output logic [FREQ_W-1:0] trk_freq_o
);
  localparam int unsigned N_RATES = 3;
  localparam int unsigned RATES [N_RATES] = '{32000, 44100, 48000};

  logic [N_RATES-1:0] hit;

  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    assign hit[g] = (det_freq_i == FREQ_W'(RATES[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk_freq_o <= '0;
    else if (en_i && det_valid_i && |hit) trk_freq_o <= det_freq_i;
  end
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch
  import ckss_pkg::*;
#(
  parameter int unsigned FREQ_W    = 17,
  parameter int unsigned CLK_KHZ   = 100000,
  parameter int unsigned SETTLE_MS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              dig_in_i,
  input  logic [FREQ_W-1:0] freq_req_i,
  input  logic              stale_i,
  input  logic              start_i,
  input  logic              det_valid_i,
  input  logic [FREQ_W-1:0] det_freq_i,
  output logic              src_sel_o,
  output logic              dac_mute_o,
  output logic              div_load_o,
  output logic [FREQ_W-1:0] div_freq_o,
  output logic              resync_in_o,
  output logic              clk_mod_o,
  output logic              clk_mod_sync_o,
  output logic              busy_o,
  output logic [FREQ_W-1:0] cur_freq_o,
  output logic [FREQ_W-1:0] trk_freq_o
);
  localparam int unsigned SETTLE_CYC = CLK_KHZ * SETTLE_MS;

  seq_st_e           st_q;
  logic              src_q, tgt_q, chg_q, mute_q;
  logic [FREQ_W-1:0] req_q, cur_q;
  logic              want_rec, tmr_start, tmr_done;

  ckss_target u_target (
    .mode_i     (mode_i),
    .dig_in_i   (dig_in_i),
    .want_rec_o (want_rec)
  );

  assign tmr_start = (st_q == ST_UNMUTE) && tgt_q;

  ckss_settle #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  ckss_rate_track #(.FREQ_W(FREQ_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (src_q && !stale_i),
    .det_valid_i (det_valid_i),
    .det_freq_i  (det_freq_i),
    .trk_freq_o  (trk_freq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= SRC_XTAL;
      tgt_q  <= SRC_XTAL;
      chg_q  <= 1'b0;
      mute_q <= 1'b0;
      req_q  <= '0;
      cur_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i && !stale_i) begin
          req_q <= freq_req_i;
          tgt_q <= want_rec;
          chg_q <= 1'b0;
          st_q  <= ST_CHECK;
        end
        ST_CHECK: if (tgt_q != src_q) begin
          mute_q <= 1'b1;       // mute lands one cycle ahead of the select
          st_q   <= ST_SWAP;
        end else begin
          st_q <= ST_FREQ;
        end
        ST_SWAP: begin
          src_q <= tgt_q;
          chg_q <= 1'b1;
          st_q  <= ST_UNMUTE;
        end
        ST_UNMUTE: begin
          mute_q <= 1'b0;
          st_q   <= tgt_q ? ST_SETTLE : ST_FREQ;
        end
        ST_SETTLE: if (tmr_done) st_q <= ST_FREQ;
        ST_FREQ: begin
          if (cur_q == req_q)  st_q <= ST_IDLE;
          else if (!tgt_q)     st_q <= ST_LOAD;
          else                 st_q <= ST_MODIFY;
        end
        ST_LOAD:   st_q <= chg_q ? ST_RESYNC : ST_MODIFY;
        ST_RESYNC: st_q <= ST_MODIFY;
        ST_MODIFY: begin
          cur_q <= req_q;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign src_sel_o      = src_q;
  assign dac_mute_o     = mute_q;
  assign div_load_o     = (st_q == ST_LOAD);
  assign div_freq_o     = req_q;
  assign resync_in_o    = (st_q == ST_RESYNC);
  assign clk_mod_o      = (st_q == ST_MODIFY);
  assign clk_mod_sync_o = (st_q == ST_MODIFY); // every modify asks for FIFO resync
  assign busy_o         = (st_q != ST_IDLE);
  assign cur_freq_o     = cur_q;
endmodule

// File: rtl/ckss_checker.sv
module ckss_checker #(
  parameter int unsigned FREQ_W = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stale_i,
  input logic              src_sel_o,
  input logic              dac_mute_o,
  input logic              div_load_o,
  input logic              resync_in_o,
  input logic              clk_mod_o,
  input logic              busy_o,
  input logic [FREQ_W-1:0] cur_freq_o,
  input logic [FREQ_W-1:0] trk_freq_o
);
  a_r2_mute_spans_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(src_sel_o) |-> dac_mute_o);

  a_r5_load_on_xtal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_load_o |-> !src_sel_o);

  a_r5_resync_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_in_o |-> $past(div_load_o));

  a_r6_modify_ends_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mod_o |=> !clk_mod_o && !busy_o);

  a_r6_freq_updates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mod_o |=> cur_freq_o != $past(cur_freq_o));

  a_r7_stale_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_i && !busy_o |=> !busy_o);

  a_r8_legal_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(trk_freq_o) |-> (trk_freq_o == FREQ_W'(32000) ||
                              trk_freq_o == FREQ_W'(44100) ||
                              trk_freq_o == FREQ_W'(48000)));

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !dac_mute_o && !div_load_o && !resync_in_o && !clk_mod_o);
endmodule

bind clk_src_switch ckss_checker #(.FREQ_W(FREQ_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stale_i     (stale_i),
  .src_sel_o   (src_sel_o),
  .dac_mute_o  (dac_mute_o),
  .div_load_o  (div_load_o),
  .resync_in_o (resync_in_o),
  .clk_mod_o   (clk_mod_o),
  .busy_o      (busy_o),
  .cur_freq_o  (cur_freq_o),
  .trk_freq_o  (trk_freq_o)
);

// File: tb/clk_src_switch_test.sv
module clk_src_switch_test;
  localparam int FW  = 17;
  localparam int KHZ = 3;
  localparam int MS  = 6;
  localparam int LIM = KHZ * MS;

  localparam int EV_MUTE_ON  = 1;
  localparam int EV_SRC      = 2;
  localparam int EV_MUTE_OFF = 3;
  localparam int EV_LOAD     = 4;
  localparam int EV_RESYNC   = 5;
  localparam int EV_MOD      = 6;
  localparam int EV_DONE     = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic dig = 1'b0, stale = 1'b0, start = 1'b0, det_valid = 1'b0;
  logic [FW-1:0] freq_req = '0, det_freq = '0;
  logic src_sel, dac_mute, div_load, resync_in, clk_mod, clk_mod_sync, busy;
  logic [FW-1:0] div_freq, cur_freq, trk_freq;

  int errors = 0, checks = 0, cyc = 0, last_cyc = 0;
  bit finished = 0;
  int qk[$], qv[$], qd[$];
  string qr[$];

  always #5 clk = ~clk;

  clk_src_switch #(.FREQ_W(FW), .CLK_KHZ(KHZ), .SETTLE_MS(MS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .dig_in_i(dig),
    .freq_req_i(freq_req), .stale_i(stale), .start_i(start),
    .det_valid_i(det_valid), .det_freq_i(det_freq),
    .src_sel_o(src_sel), .dac_mute_o(dac_mute), .div_load_o(div_load),
    .div_freq_o(div_freq), .resync_in_o(resync_in), .clk_mod_o(clk_mod),
    .clk_mod_sync_o(clk_mod_sync), .busy_o(busy), .cur_freq_o(cur_freq),
    .trk_freq_o(trk_freq));

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ev(int k, int v, int d, string req);
    qk.push_back(k); qv.push_back(v); qd.push_back(d); qr.push_back(req);
  endtask

  task automatic got(int k, int v);
    int ek, ev, ed;
    string er;
    if (qk.size() == 0) begin
      chk(0, "unexpected event", k, 0);
    end else begin
      ek = qk.pop_front(); ev = qv.pop_front();
      ed = qd.pop_front(); er = qr.pop_front();
      chk(k == ek, er, k, ek);
      if (ev >= 0) chk(v == ev, er, v, ev);
      if (ed >= 0) chk(cyc - last_cyc == ed, {er, " timing"}, cyc - last_cyc, ed);
    end
    last_cyc = cyc;
  endtask

  // monitor
  logic p_mute = 0, p_src = 0, p_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (dac_mute && !p_mute) got(EV_MUTE_ON, 1);
      if (src_sel != p_src) begin
        got(EV_SRC, int'(src_sel));
        chk(dac_mute, "R2 mute high at select change", int'(dac_mute), 1);
      end
      if (!dac_mute && p_mute) got(EV_MUTE_OFF, 0);
      if (div_load) got(EV_LOAD, int'(div_freq));
      if (resync_in) got(EV_RESYNC, 1);
      if (clk_mod) got(EV_MOD, int'(clk_mod_sync));
      if (!busy && p_busy) got(EV_DONE, int'(cur_freq));
      p_mute = dac_mute; p_src = src_sel; p_busy = busy;
    end
  end

  task automatic run(int m, bit d, int f, bit expect_busy, string req);
    @(negedge clk);
    mode = m[1:0]; dig = d; freq_req = FW'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == expect_busy, {req, " R9 busy after start"}, int'(busy), int'(expect_busy));
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(qk.size() == 0, {req, " all expected events seen"}, qk.size(), 0);
    qk.delete(); qv.delete(); qd.delete(); qr.delete();
  endtask

  task automatic report(int f, bit v);
    @(negedge clk);
    det_freq = FW'(f); det_valid = v;
    @(negedge clk);
    det_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(src_sel == 0 && dac_mute == 0 && busy == 0, "R10 reset outputs",
        int'({src_sel, dac_mute, busy}), 0);
    chk(cur_freq == 0 && trk_freq == 0, "R10 reset freqs", int'(cur_freq) + int'(trk_freq), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 internal, no switch; R5 load without resync; R6 modify
    expect_ev(EV_LOAD, 48000, -1, "R5 load word");
    expect_ev(EV_MOD, 1, 1, "R6 modify with sync");
    expect_ev(EV_DONE, 48000, 1, "R6 cur_freq updated");
    run(0, 0, 48000, 1, "S1");

    // R4 same frequency: nothing
    expect_ev(EV_DONE, 48000, -1, "R4 no action");
    run(0, 0, 48000, 1, "S2");

    // R1 external -> recovered; R2 mute; R3 settle; R6 no load
    expect_ev(EV_MUTE_ON, 1, -1, "R2 mute first");
    expect_ev(EV_SRC, 1, 1, "R1 external selects recovered");
    expect_ev(EV_MUTE_OFF, 0, 1, "R2 unmute after");
    expect_ev(EV_MOD, 1, LIM + 1, "R3 settle before modify");
    expect_ev(EV_DONE, 44100, 1, "R6 cur_freq 44100");
    run(1, 0, 44100, 1, "S3");

    // R1 auto+digital stays on recovered, same freq
    expect_ev(EV_DONE, 44100, -1, "R4 auto digital no action");
    run(2, 1, 44100, 1, "S4");

    // R8 tracker on recovered
    report(44100, 1);
    chk(trk_freq == 44100, "R8 accept 44100", int'(trk_freq), 44100);
    report(44000, 1);
    chk(trk_freq == 44100, "R8 reject 44000", int'(trk_freq), 44100);
    report(32000, 0);
    chk(trk_freq == 44100, "R8 ignore without valid", int'(trk_freq), 44100);
    report(48000, 1);
    chk(trk_freq == 48000, "R8 accept 48000", int'(trk_freq), 48000);

    // R1 auto+analog -> crystal; R3 no wait; R5 resync after load
    expect_ev(EV_MUTE_ON, 1, -1, "R2 mute first");
    expect_ev(EV_SRC, 0, 1, "R1 auto analog selects crystal");
    expect_ev(EV_MUTE_OFF, 0, 1, "R2 unmute after");
    expect_ev(EV_LOAD, 32000, 1, "R3 no wait toward crystal");
    expect_ev(EV_RESYNC, 1, 1, "R5 resync after source change");
    expect_ev(EV_MOD, 1, 1, "R6 modify with sync");
    expect_ev(EV_DONE, 32000, 1, "R6 cur_freq 32000");
    run(2, 0, 32000, 1, "S5");

    // R8 ignored on crystal
    report(44100, 1);
    chk(trk_freq == 48000, "R8 ignored on crystal", int'(trk_freq), 48000);

    // R1 mode 3 is internal
    expect_ev(EV_DONE, 32000, -1, "R1 mode 3 internal");
    run(3, 1, 32000, 1, "S6");

    // R7 stale blocks request
    stale = 1'b1;
    run(1, 0, 48000, 0, "R7 stale");
    chk(src_sel == 0 && dac_mute == 0 && cur_freq == 32000, "R7 outputs unchanged",
        int'(src_sel), 0);
    stale = 1'b0;

    // R3 settle then end without modify; R4 no load
    expect_ev(EV_MUTE_ON, 1, -1, "R2 mute first");
    expect_ev(EV_SRC, 1, 1, "R1 external selects recovered");
    expect_ev(EV_MUTE_OFF, 0, 1, "R2 unmute after");
    expect_ev(EV_DONE, 32000, LIM + 1, "R3 settle before end");
    run(1, 0, 32000, 1, "S8");

    // R4 switch back, same freq: no load, no resync
    expect_ev(EV_MUTE_ON, 1, -1, "R2 mute first");
    expect_ev(EV_SRC, 0, 1, "R1 internal selects crystal");
    expect_ev(EV_MUTE_OFF, 0, 1, "R2 unmute after");
    expect_ev(EV_DONE, 32000, 1, "R4 no load after switch");
    run(0, 1, 32000, 1, "S9");

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule